// File: doc/BRIEF.md
# Cartesian Bit-Addressed Pixel Plotter

This block plots pixels into a monochrome frame buffer that stores one bit per pixel. A command gives an (x, y) coordinate. The block turns it into a linear bit address using two programmable values. The origin value is the bit address of the upper-left pixel. The row pitch value is the bit distance between a pixel and the one directly below it. Rows therefore need not start on a word boundary. Moving right adds one to the bit address, and moving down adds the pitch. The block then sets the pixel with a read-modify-write cycle on a 32-bit synchronous memory port, which returns read data a fixed number of cycles after each request.

A command either sets a single pixel or sets a 2x2 block of pixels. For a 2x2 block, the four bits are visited in a fixed order. When consecutive bits in that order land in the same memory word, they share one read and one write. Commands use a valid/ready handshake and are taken only while the block is idle. A one-cycle completion pulse follows the last write.

Top module: `pix_plot`

## Requirements
- R1: After reset, cmd_ready is 1, mem_rd_en, mem_wr_en and done are 0, and both the origin and the pitch are 0.
- R2: A cycle with cfg_org_we = 1 loads cfg_val into the origin, and a cycle with cfg_warp_we = 1 loads cfg_val into the pitch. Both are 24-bit unsigned values.
- R3: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready stays 0 from that edge until the cycle after done, and cmd_valid has no effect while cmd_ready is 0.
- R4: The pixel bit address is origin + y*pitch + x. The memory word address is that bit address shifted right by 5. The pixel occupies data bit (bit address mod 32), so data bit 0 is the leftmost pixel of the word.
- R5: A pixel is set by reading its word and then writing back the read data OR'd with a one-hot mask. All other bits are kept.
- R6: The write for a group is issued in the cycle exactly RD_LAT cycles after its read request, at the same word address, and a read and a write are never asserted in the same cycle.
- R7: With cmd_fat = 1, the bits set are, in order, those of (x,y), (x+1,y), (x,y+1) and (x+1,y+1). They are reached from the base address by steps of +1, +(pitch-1) and +1.
- R8: Consecutive 2x2 bits that fall in the same word are merged into one read and one write, so a 2x2 command makes between one and four read-modify-write pairs.
- R9: done is a one-cycle pulse, asserted in the cycle after the final write of a command.
- R10: All bit-address arithmetic wraps modulo 2^24.
- R11: A pitch or origin write in the same cycle that a command is accepted applies to that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_org_we | input | 1 | Load the origin from cfg_val |
| cfg_warp_we | input | 1 | Load the pitch from cfg_val |
| cfg_val | input | AW | Configuration value |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_fat | input | 1 | 1 = 2x2 block, 0 = single pixel |
| cmd_x | input | XW | Column coordinate |
| cmd_y | input | YW | Row coordinate |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | AW-5 | Word address for read or write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after the request |
| done | output | 1 | Command complete pulse |

## Verification
A configuration write and a command acceptance can happen in the same cycle. The bench provokes this by raising cfg_warp_we together with cmd_valid while the block is idle. It then judges the result from the word addresses and write data on the memory port. These must match a model that already uses the new pitch for that same command. A command that stays valid after acceptance overlaps the busy period. In that case the bench checks that no extra memory traffic appears beyond what the first command predicts.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;
    localparam int NPIX   = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CALC = 3'd1,
        ST_READ = 3'd2,
        ST_WAIT = 3'd3,
        ST_DONE = 3'd4
    } seq_st_e;
endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          org_we,
    input  logic          warp_we,
    input  logic [AW-1:0] val,
    output logic [AW-1:0] org_q,
    output logic [AW-1:0] warp_q
);
    typedef struct packed {
        logic [AW-1:0] org;
        logic [AW-1:0] warp;
    } cfg_s;

    cfg_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (org_we)  c_d.org  = val;
        if (warp_we) c_d.warp = val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign org_q  = c_q.org;
    assign warp_q = c_q.warp;

    p_org_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(org_we)) |-> (org_q == $past(val)));
    p_warp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(warp_we)) |-> (warp_q == $past(val)));
endmodule

// File: rtl/pix_addr_gen.sv
module pix_addr_gen import pix_pkg::*; #(
    parameter int AW = 24,
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic [AW-1:0]           org,
    input  logic [AW-1:0]           warp,
    input  logic [XW-1:0]           x,
    input  logic [YW-1:0]           y,
    output logic [NPIX-1:0][AW-1:0] pt
);
    logic [AW-1:0] row_off;
    logic [NPIX-1:0][AW-1:0] step;

    assign row_off = AW'(y) * warp;
    assign pt[0]   = org + row_off + AW'(x);

    // step sequence: right, down-left, right
    assign step[0] = '0;
    assign step[1] = AW'(1);
    assign step[2] = warp - AW'(1);
    assign step[3] = AW'(1);

    generate
        for (genvar i = 1; i < NPIX; i++) begin : g_walk
            assign pt[i] = pt[i-1] + step[i];
        end
    endgenerate
endmodule

// File: rtl/pix_rmw_seq.sv
module pix_rmw_seq import pix_pkg::*; #(
    parameter int AW     = 24,
    parameter int XW     = 12,
    parameter int YW     = 12,
    parameter int RD_LAT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic                    cmd_fat,
    input  logic [XW-1:0]           cmd_x,
    input  logic [YW-1:0]           cmd_y,
    output logic [XW-1:0]           lat_x,
    output logic [YW-1:0]           lat_y,
    input  logic [NPIX-1:0][AW-1:0] pt_in,
    output logic                    mem_rd_en,
    output logic                    mem_wr_en,
    output logic [AW-IDX_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    done
);
    localparam int WA_W  = AW - IDX_W;
    localparam int CNT_W = $clog2(RD_LAT + 1) + 1;

    typedef struct packed {
        seq_st_e                 st;
        logic                    fat;
        logic [XW-1:0]           x;
        logic [YW-1:0]           y;
        logic [NPIX-1:0][AW-1:0] pt;
        logic [2:0]              k;
        logic [CNT_W-1:0]        cnt;
        logic [WORD_W-1:0]       mask;
        logic [WA_W-1:0]         waddr;
    } seq_s;

    seq_s s_d, s_q;

    // group of consecutive same-word pixels starting at index k
    logic [WORD_W-1:0] g_mask;
    logic [WA_W-1:0]   g_wa;
    logic [2:0]        g_nxt;
    logic              g_chain;
    logic [2:0]        n_pix;

    assign n_pix = s_q.fat ? 3'(NPIX) : 3'd1;

    always_comb begin
        g_wa    = s_q.pt[s_q.k[1:0]][AW-1:IDX_W];
        g_mask  = WORD_W'(1) << s_q.pt[s_q.k[1:0]][IDX_W-1:0];
        g_nxt   = s_q.k + 3'd1;
        g_chain = 1'b1;
        for (int i = 0; i < NPIX; i++) begin
            if (3'(i) > s_q.k && 3'(i) < n_pix) begin
                if (g_chain && s_q.pt[i][AW-1:IDX_W] == g_wa) begin
                    g_mask = g_mask | (WORD_W'(1) << s_q.pt[i][IDX_W-1:0]);
                    g_nxt  = 3'(i + 1);
                end else begin
                    g_chain = 1'b0;
                end
            end
        end
    end

    always_comb begin
        s_d       = s_q;
        cmd_ready = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = s_q.waddr;
        mem_wdata = mem_rdata | s_q.mask;
        done      = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    s_d.fat = cmd_fat;
                    s_d.x   = cmd_x;
                    s_d.y   = cmd_y;
                    s_d.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                s_d.pt = pt_in;
                s_d.k  = 3'd0;
                s_d.st = ST_READ;
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                mem_addr  = g_wa;
                s_d.waddr = g_wa;
                s_d.mask  = g_mask;
                s_d.k     = g_nxt;
                s_d.cnt   = CNT_W'(1);
                s_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (s_q.cnt == CNT_W'(RD_LAT)) begin
                    mem_wr_en = 1'b1;
                    s_d.st    = (s_q.k >= n_pix) ? ST_DONE : ST_READ;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lat_x = s_q.x;
    assign lat_y = s_q.y;

    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    p_wr_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $stable(mem_addr));
    p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_rd_en && !mem_wr_en && !done));
    p_keep_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_wdata & mem_rdata) == mem_rdata));
    p_done_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_wr_en));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));
endmodule

// File: rtl/pix_plot.sv
module pix_plot import pix_pkg::*; #(
    parameter int AW     = 24,
    parameter int XW     = 12,
    parameter int YW     = 12,
    parameter int RD_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_org_we,
    input  logic                cfg_warp_we,
    input  logic [AW-1:0]       cfg_val,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_fat,
    input  logic [XW-1:0]       cmd_x,
    input  logic [YW-1:0]       cmd_y,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [AW-IDX_W-1:0] mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                done
);
    logic [AW-1:0]           org_q, warp_q;
    logic [XW-1:0]           lat_x;
    logic [YW-1:0]           lat_y;
    logic [NPIX-1:0][AW-1:0] pt;

    pix_cfg_regs #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .org_we(cfg_org_we), .warp_we(cfg_warp_we), .val(cfg_val),
        .org_q(org_q), .warp_q(warp_q)
    );

    pix_addr_gen #(.AW(AW), .XW(XW), .YW(YW)) u_addr (
        .org(org_q), .warp(warp_q), .x(lat_x), .y(lat_y), .pt(pt)
    );

    pix_rmw_seq #(.AW(AW), .XW(XW), .YW(YW), .RD_LAT(RD_LAT)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fat(cmd_fat),
        .cmd_x(cmd_x), .cmd_y(cmd_y),
        .lat_x(lat_x), .lat_y(lat_y), .pt_in(pt),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );
endmodule

// File: tb/sim_pix_plot.sv
`timescale 1ns/1ps
module sim_pix_plot;
    localparam int AW = 24, XW = 12, YW = 12, RD_LAT = 2;
    localparam int WA_W = AW - 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_org_we = 0, cfg_warp_we = 0;
    logic [AW-1:0] cfg_val = '0;
    logic cmd_valid = 0, cmd_fat = 0, cmd_ready;
    logic [XW-1:0] cmd_x = '0;
    logic [YW-1:0] cmd_y = '0;
    logic mem_rd_en, mem_wr_en, done;
    logic [WA_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;

    always #2.5 clk = ~clk;

    pix_plot #(.AW(AW), .XW(XW), .YW(YW), .RD_LAT(RD_LAT)) u0 (.*);

    typedef struct {
        bit          wr;
        int          addr;
        logic [31:0] data;
        string       tag;
    } op_t;

    op_t exp_q[$];
    logic [31:0] mem [int];
    logic [31:0] shadow [int];
    int checks = 0, fails = 0, cyc = 0, rd_cyc = 0, wr_cyc = -10, done_cnt = 0;
    logic [AW-1:0] org_m = '0, warp_m = '0;

    function automatic logic [31:0] seed(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h0F0F00F0;
    endfunction

    function automatic logic [31:0] shadow_get(int a);
        return shadow.exists(a) ? shadow[a] : seed(a);
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // memory model with fixed read latency
    always @(posedge clk) begin
        logic [WA_W-1:0] pipe [RD_LAT];
        if (mem_wr_en) mem[int'(mem_addr)] = mem_wdata;
        for (int i = RD_LAT - 1; i > 0; i--) pipe[i] = pipe[i-1];
        pipe[0] = mem_addr;
        mem_rdata <= mem.exists(int'(pipe[RD_LAT-1])) ? mem[int'(pipe[RD_LAT-1])]
                                                      : seed(int'(pipe[RD_LAT-1]));
    end

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected memory traffic
    always @(negedge clk) begin
        if (rst_n && (mem_rd_en || mem_wr_en)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3", "unexpected memory op, addr", longint'(mem_addr), 0);
            end else begin
                op_t e;
                e = exp_q.pop_front();
                chk(mem_wr_en == e.wr, e.tag, "op kind (1=write)", longint'(mem_wr_en), longint'(e.wr));
                chk(int'(mem_addr) == e.addr, e.tag, "word address", longint'(mem_addr), longint'(e.addr));
                if (mem_wr_en) begin
                    chk(mem_wdata == e.data, e.tag, "write data", longint'(mem_wdata), longint'(e.data));
                    chk(cyc - rd_cyc == RD_LAT, "R6", "read-to-write cycles", cyc - rd_cyc, RD_LAT);
                    wr_cyc = cyc;
                end else begin
                    rd_cyc = cyc;
                end
            end
        end
        if (rst_n && done) begin
            chk(wr_cyc == cyc - 1, "R9", "done after last write", cyc - wr_cyc, 1);
            chk(exp_q.size() == 0, "R8", "ops left at done", exp_q.size(), 0);
            done_cnt++;
        end
    end

    task automatic cfg_write(bit is_org, logic [AW-1:0] v);
        @(negedge clk);
        cfg_val = v;
        if (is_org) begin cfg_org_we = 1; org_m = v; end
        else        begin cfg_warp_we = 1; warp_m = v; end
        @(negedge clk);
        cfg_org_we = 0; cfg_warp_we = 0;
    endtask

    // driver: pushes expected ops then issues the command
    task automatic plot(bit fat, int x, int y, string tag,
                        bit same_warp = 0, logic [AW-1:0] nw = '0, int hold = 0);
        logic [AW-1:0] a [4];
        int n, i, d0;
        if (same_warp) warp_m = nw;
        a[0] = org_m + AW'(y) * warp_m + AW'(x);
        a[1] = a[0] + 1;
        a[2] = a[0] + warp_m;
        a[3] = a[2] + 1;
        n = fat ? 4 : 1;
        i = 0;
        while (i < n) begin
            int w;
            logic [31:0] m;
            logic [31:0] d;
            w = int'(a[i] >> 5);
            m = '0;
            do begin
                m[a[i][4:0]] = 1'b1;
                i++;
            end while (i < n && int'(a[i] >> 5) == w);
            exp_q.push_back('{0, w, '0, tag});
            d = shadow_get(w) | m;
            shadow[w] = d;
            exp_q.push_back('{1, w, d, tag});
        end
        @(negedge clk);
        chk(cmd_ready == 1, "R3", "ready when idle", longint'(cmd_ready), 1);
        d0 = done_cnt;
        cmd_valid = 1; cmd_fat = fat; cmd_x = XW'(x); cmd_y = YW'(y);
        if (same_warp) begin cfg_warp_we = 1; cfg_val = nw; end
        @(negedge clk);
        cfg_warp_we = 0;
        for (int h = 0; h < hold; h++) begin
            chk(cmd_ready == 0, "R3", "ready while busy", longint'(cmd_ready), 0);
            cmd_x = cmd_x + 7;
            @(negedge clk);
        end
        cmd_valid = 0;
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1, "R1", "cmd_ready", longint'(cmd_ready), 1);
        chk(!mem_rd_en && !mem_wr_en && !done, "R1", "rd/wr/done", longint'({mem_rd_en, mem_wr_en, done}), 0);
        // R1 origin and pitch reset to 0: (5,3) lands on bit 5
        plot(0, 5, 3, "R1");
        // R2 R4 plain pitch
        cfg_write(0, 24'd640);
        plot(0, 3, 2, "R4");
        // R5 pixel already set: write equals read
        plot(0, 3, 2, "R5");
        // R2 unaligned rows
        cfg_write(1, 24'd5);
        cfg_write(0, 24'd37);
        plot(0, 7, 4, "R2");
        // R7 R8 2x2 with pairs merged
        plot(1, 30, 1, "R7");
        // R8 2x2 across a word edge
        cfg_write(1, 24'd31);
        cfg_write(0, 24'd100);
        plot(1, 0, 0, "R8");
        // R8 pitch 1: all four bits in one word
        cfg_write(1, 24'd64);
        cfg_write(0, 24'd1);
        plot(1, 2, 0, "R8");
        // R7 pitch 0: steps revisit bits
        cfg_write(0, 24'd0);
        plot(1, 0, 0, "R7");
        // R10 wrap of x term and of row term
        cfg_write(1, 24'hFFFFF0);
        cfg_write(0, 24'd8);
        plot(1, 20, 0, "R10");
        cfg_write(0, 24'h800000);
        plot(0, 1, 3, "R10");
        // R3 valid held with other coordinates while busy
        cfg_write(1, 24'd0);
        cfg_write(0, 24'd96);
        plot(0, 9, 1, "R3", 0, '0, 2);
        // R11 pitch written in the acceptance cycle
        plot(1, 1, 1, "R11", 1, 24'd50);
        plot(1, 31, 2, "R11");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "leftover expected ops", exp_q.size(), 0);
        report();
    end
endmodule